// File: doc/BRIEF.md
# MDIO Management Interface Controller

This controller carries out PHY management register reads and writes over the two-wire MDC/MDIO serial interface. A host loads one 32-bit command word with a single write strobe. The word holds the operation, the PHY address, the register number and, for writes, 16 data bits. The controller then sends a complete management frame with the most significant bit first. It derives MDC from the system clock through a 3-bit encoded divisor.

A read frame works in two parts. The controller first releases MDIO at turnaround. It then samples the 16 bits the PHY returns, and writes them back into the low half of the same command register when the frame ends. An idle flag stays low for the whole frame. The host polls this flag before it issues a new command or collects read data. A command that arrives while the flag is low is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` reads 0.
- R2: The divisor code on `div_sel` sets the MDC period N in system cycles: code 0 gives 8, 1 gives 16, 2 gives 32, 3 gives 48, 4 gives 64, 5 gives 96, 6 gives 128 and 7 gives 224. MDC is low for the first N/2 cycles of every bit period and high for the second N/2.
- R3: The command word layout is: bits 29:28 opcode (10 = read, 01 = write), bits 27:23 PHY address, bits 22:18 register number (0 to 31), bits 15:0 data. The other bits are stored but not used. A `cmd_we` pulse while `idle` is 1 loads the word into `cmd_rdata` and drops `idle` on the next cycle.
- R4: A frame is 64 MDC periods. It sends, in this order: 32 ones, start bits 0 then 1, the two opcode bits, the PHY address MSB first, the register number MSB first, two turnaround bits, and 16 data bits MSB first.
- R5: In a write frame, MDIO is driven for all 64 bits, the turnaround is 1 then 0, and the data field is bits 15:0 of the command. A write leaves `cmd_rdata` unchanged.
- R6: In a read frame, `mdio_oe` is 0 from the first turnaround bit to the end of the frame. MDIO is sampled on each MDC rising edge of the 16 data bits, and at completion bits 15:0 of `cmd_rdata` take the sampled value, first bit in bit 15. Bits 31:16 are unchanged.
- R7: While a frame runs, `mdio_o` changes only on a falling edge of MDC.
- R8: `idle` returns to 1 exactly 64*N system cycles after the command was accepted. While `idle` is 1, `mdc` stays 0 and `mdio_oe` stays 0.
- R9: A `cmd_we` pulse while `idle` is 0 is ignored: `cmd_rdata` keeps its value, `idle` stays 0 and the frame in flight is unchanged.
- R10: The divisor code is captured when a command is accepted. Changes on `div_sel` during the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word to load |
| cmd_rdata | output | 32 | Command/data register contents |
| idle | output | 1 | 1 when no frame is in progress |
| div_sel | input | 3 | MDC divisor code |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = controller drives) |
| mdio_i | input | 1 | MDIO input value from the pad |

## Verification
Counting from the clock edge that accepts a command, `idle` goes low one edge later. The first MDC rising edge comes N/2 edges after acceptance. Bit k is on MDIO from edge k*N to edge (k+1)*N and is sampled at edge k*N+N/2. The frame ends with `idle` high and the read data in the register at edge 64*N. The bench counts edges from acceptance at every falling clock edge and records MDIO at each MDC rising edge. It compares the duration, the first-rise offset, the bit sequence, the drive-enable pattern and the final register against those edge numbers. The PHY model changes `mdio_i` only while MDC is low, so each value is stable at the sampling edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 32;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int DIV_W     = 3;

    // field positions inside the command word
    localparam int OP_LO   = 28;
    localparam int PHY_LO  = 23;
    localparam int REG_LO  = 18;

    // bit positions inside the frame
    localparam int TA_POS   = PRE_LEN + 14;
    localparam int DATA_POS = PRE_LEN + 16;

    typedef enum logic [1:0] {
        OP_WR = 2'b01,
        OP_RD = 2'b10
    } mdio_op_e;

    function automatic logic [7:0] mdc_ratio(input logic [DIV_W-1:0] code);
        logic [7:0] r;
        case (code)
            3'd0:    r = 8'd8;
            3'd1:    r = 8'd16;
            3'd2:    r = 8'd32;
            3'd3:    r = 8'd48;
            3'd4:    r = 8'd64;
            3'd5:    r = 8'd96;
            3'd6:    r = 8'd128;
            default: r = 8'd224;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             mdc,
    output logic             rise_en,
    output logic             fall_en
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_st_t;

    gen_st_t          s_d, s_q;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    always_comb begin
        half_m1 = CNT_W'(mdc_ratio(div_code) >> 1) - CNT_W'(1);
        wrap    = run && (s_q.cnt == half_m1);
        s_d     = s_q;
        if (!run) begin
            s_d = '0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
        rise_en = wrap && !s_q.mdc;
        fall_en = wrap && s_q.mdc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc = s_q.mdc;

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise_en,
    input  logic              fall_en,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic                 busy;
        logic                 is_read;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic [DATA_W-1:0]    rd;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    last;

    always_comb begin
        s_d  = s_q;
        last = (s_q.idx == IDX_W'(FRAME_LEN - 1));
        if (start && !s_q.busy) begin
            s_d.busy    = 1'b1;
            s_d.is_read = (op == OP_RD);
            s_d.idx     = '0;
            s_d.rd      = '0;
            s_d.sh      = {{PRE_LEN{1'b1}}, 2'b01, op, phy_addr, reg_addr,
                           2'b10, wdata};
        end else if (s_q.busy) begin
            if (rise_en && s_q.is_read && s_q.idx >= IDX_W'(DATA_POS))
                s_d.rd = {s_q.rd[DATA_W-2:0], mdio_i};
            if (fall_en) begin
                if (last) begin
                    s_d.busy = 1'b0;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                    s_d.sh  = {s_q.sh[FRAME_LEN-2:0], 1'b1};
                end
            end
        end
        busy    = s_q.busy;
        mdio_o  = s_q.busy ? s_q.sh[FRAME_LEN-1] : 1'b1;
        mdio_oe = s_q.busy && !(s_q.is_read && s_q.idx >= IDX_W'(TA_POS));
        rd_done = s_q.busy && s_q.is_read && fall_en && last;
        rd_data = s_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic             idle,
    input  logic [DIV_W-1:0] div_sel,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [DIV_W-1:0] div;
    } top_st_t;

    top_st_t           s_d, s_q;
    logic              busy, accept, rise_en, fall_en, rd_done;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        accept = cmd_we && !busy;
        s_d    = s_q;
        if (accept) begin
            s_d.cmd = cmd_wdata;
            s_d.div = div_sel;
        end else if (rd_done) begin
            s_d.cmd[DATA_W-1:0] = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .div_code (s_q.div),
        .mdc      (mdc),
        .rise_en  (rise_en),
        .fall_en  (fall_en)
    );

    mdio_frame_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .op       (cmd_wdata[OP_LO+1:OP_LO]),
        .phy_addr (cmd_wdata[PHY_LO+ADDR_W-1:PHY_LO]),
        .reg_addr (cmd_wdata[REG_LO+ADDR_W-1:REG_LO]),
        .wdata    (cmd_wdata[DATA_W-1:0]),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

    assign cmd_rdata = s_q.cmd;
    assign idle      = !busy;

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [31:0] cmd_rdata,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    // R3
    accept_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_we) |=> !idle);

    // R9
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cmd_we) |=> (idle || $stable(cmd_rdata)));

    // R5
    write_keeps_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && cmd_rdata[29:28] != 2'b10) |=> $stable(cmd_rdata));

    // R7
    data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && $past(!idle) && !$stable(mdio_o)) |-> $fell(mdc));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mdc && !mdio_oe));

    // R8
    mdc_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> !idle);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_rdata (cmd_rdata),
    .idle      (idle),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic [2:0]  div_sel = '0;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .idle(idle), .div_sel(div_sel), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic int ratio(input logic [2:0] c);
        case (c)
            3'd0: return 8;    3'd1: return 16;  3'd2: return 32;  3'd3: return 48;
            3'd4: return 64;   3'd5: return 96;  3'd6: return 128; default: return 224;
        endcase
    endfunction

    function automatic logic exp_bit(input logic [31:0] c, input int k);
        if (k < 32)  return 1'b1;
        if (k == 32) return 1'b0;
        if (k == 33) return 1'b1;
        if (k < 36)  return c[29 - (k - 34)];
        if (k < 41)  return c[27 - (k - 36)];
        if (k < 46)  return c[22 - (k - 41)];
        if (k == 46) return 1'b1;
        if (k == 47) return 1'b0;
        return c[15 - (k - 48)];
    endfunction

    function automatic logic exp_oe(input logic [31:0] c, input int k);
        return !(c[29:28] == 2'b10 && k >= 46);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [31:0] c, input logic [2:0] code,
                           input logic [15:0] rdval, input bit poke, input bit chg_div);
        logic [63:0] got_o, got_oe, want_o, want_oe, mask;
        int n, cyc, rc, first_rise, viol;
        logic prev_mdc, prev_o;
        n = ratio(code);
        got_o = '0; got_oe = '0;
        @(negedge clk);
        cmd_wdata = c; div_sel = code; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        // R3: loaded and busy one edge after acceptance
        chk(!idle && cmd_rdata == c, "R3", {31'd0, idle, cmd_rdata}, {32'd0, c});
        cyc = 0; rc = 0; first_rise = -1; viol = 0;
        prev_mdc = mdc; prev_o = mdio_o;
        while (!idle && cyc < 70000) begin
            if (!mdc) mdio_i = (rc >= 48 && rc < 64) ? rdval[63 - rc] : 1'b1;
            if (poke && cyc == 100) begin
                cmd_we = 1'b1; cmd_wdata = ~c;
            end
            if (chg_div && cyc == 50) div_sel = ~code;
            @(negedge clk);
            cyc++;
            if (poke && cyc == 101) begin
                cmd_we = 1'b0;
                // R9: busy command ignored
                chk(!idle && cmd_rdata == c, "R9", {31'd0, idle, cmd_rdata}, {32'd0, c});
            end
            if (!idle && mdio_o != prev_o && !(prev_mdc && !mdc)) viol++;
            if (mdc && !prev_mdc) begin
                if (rc < 64) begin
                    got_o[rc] = mdio_o; got_oe[rc] = mdio_oe;
                end
                if (first_rise < 0) first_rise = cyc;
                rc++;
            end
            prev_mdc = mdc; prev_o = mdio_o;
        end
        for (int k = 0; k < 64; k++) begin
            want_o[k]  = exp_bit(c, k);
            want_oe[k] = exp_oe(c, k);
        end
        mask = want_oe;
        // R8: duration and quiet lines afterwards
        chk(cyc == 64 * n, "R8", cyc, 64 * n);
        chk(!mdc && !mdio_oe, "R8", {mdc, mdio_oe}, 2'b00);
        // R2: MDC period and phase (R10: code captured at acceptance)
        chk(first_rise == n / 2 && rc == 64, chg_div ? "R10" : "R2",
            {first_rise[31:0], rc[31:0]}, {32'(n / 2), 32'd64});
        // R4: frame bit sequence where the controller drives
        chk((got_o & mask) == (want_o & mask), "R4", got_o & mask, want_o & mask);
        // R5/R6: drive enable pattern
        chk(got_oe == want_oe, c[29:28] == 2'b10 ? "R6" : "R5", got_oe, want_oe);
        // R7: output changes only on falling MDC
        chk(viol == 0, "R7", viol, 0);
        if (c[29:28] == 2'b10)
            chk(cmd_rdata == {c[31:16], rdval}, "R6", cmd_rdata, {c[31:16], rdval});
        else
            chk(cmd_rdata == c, "R5", cmd_rdata, c);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(idle && !mdc && !mdio_oe && cmd_rdata == 0, "R1",
            {idle, mdc, mdio_oe, cmd_rdata}, {3'b100, 32'd0});
        // directed: write, all-ones address, divisor 0
        run_cmd({2'b00, 2'b01, 5'h1F, 5'h00, 2'b00, 16'hA5C3}, 3'd0, 16'h0, 0, 0);
        // directed: read, register 31, divisor 3, edge data pattern
        run_cmd({2'b00, 2'b10, 5'h00, 5'h1F, 2'b00, 16'h0000}, 3'd3, 16'h8001, 0, 0);
        // directed: busy poke during a read
        run_cmd({2'b11, 2'b10, 5'h0A, 5'h15, 2'b00, 16'hFFFF}, 3'd1, 16'h5A3C, 1, 0);
        // directed: divisor select changed mid frame
        run_cmd({2'b00, 2'b01, 5'h05, 5'h0B, 2'b00, 16'h1234}, 3'd2, 16'h0, 0, 1);
        // random commands over every divisor code
        for (int d = 0; d < 8; d++) begin
            logic [31:0] rc32;
            rc32 = $urandom;
            rc32[29:28] = ($urandom % 2 == 0) ? 2'b10 : 2'b01;
            run_cmd(rc32, 3'(d), 16'($urandom), 0, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule